// File: doc/BRIEF.md
# Capture Compare PWM Channel

This block is one channel of a timer unit. A shared counter outside the block supplies the running count, its direction and the modulus. It also supplies a bit that says whether the counter runs up-only (edge alignment) or up/down (center alignment). The channel turns these into one of three functions, chosen by a mode field. In capture mode it stores the count when a selected edge arrives on a pin that it first synchronizes. In compare mode it sets, clears or toggles its output pin when the count equals its value register. In PWM mode it drives a pulse train whose width comes from the value register and whose polarity is selectable.

In PWM mode a new duty value goes into a shadow register. It is copied into the active value register only at the end of a counter period, so a write never produces a truncated pulse. An edge-aligned counter and an up/down counter use the same active register and the same comparison. The channel sets an event flag on every capture or match. Software clears the flag with a pulse, and the flag gated by an enable forms the channel's interrupt request.

Top module: `ccp_channel`

## Requirements
- R1: While reset is asserted and straight after it, ch_out, flag and irq are 0 and ch_val is 0.
- R2: cap_pin passes through two flip-flops before edge detection. A pin change is acted on at the third rising clock edge after it. In capture mode (mode = 2'b00) a qualifying edge stores into ch_val the count present at that clock edge.
- R3: The capture trigger follows edge_sel: 2'b01 rising only, 2'b10 falling only, 2'b11 either, 2'b00 none. A non-selected edge leaves the flag and ch_val unchanged.
- R4: In compare mode (mode = 2'b01), a clock edge at which cnt equals ch_val applies cmp_act to ch_out from the next cycle: 2'b11 set, 2'b10 clear, 2'b01 toggle, 2'b00 no change.
- R5: flag becomes 1 after any capture or match (compare and PWM modes). A flag_clr pulse clears it unless a new event occurs in the same cycle, in which case the set wins. irq is flag AND irq_en.
- R6: In capture, compare and off modes a wr_val pulse loads wr_data into ch_val at the next edge. In PWM mode (mode = 2'b10) the write goes only to the shadow register. The shadow value moves to ch_val at the edge where cnt equals mod_val, and with center_mode = 1 only while cnt_down is 0.
- R7: In PWM mode with center_mode = 0 and pol_low = 0, ch_out after an edge is 1 exactly when the count at that edge was below ch_val. This gives duty ch_val/(mod_val+1) per period, 0% for ch_val = 0 and 100% for ch_val > mod_val.
- R8: With center_mode = 1 the same rule gives a centered pulse: ch_out goes low at the match while counting up and high again while counting down. For ch_val = 4 and mod_val = 9 it is high 7 cycles of each 18-cycle period.
- R9: pol_low = 1 inverts the PWM output at once (low-true pulses).
- R10: mode = 2'b11 turns the channel off: ch_out is 0, no capture or match sets the flag, and ch_val changes only by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt | input | CNT_W | Shared counter value |
| cnt_down | input | 1 | 1 while the shared counter counts down |
| center_mode | input | 1 | 1 for up/down (center-aligned) counting |
| mod_val | input | CNT_W | Counter modulus (last count of a period) |
| mode | input | 2 | 00 capture, 01 compare, 10 PWM, 11 off |
| edge_sel | input | 2 | Capture edge select |
| cmp_act | input | 2 | Compare action select |
| pol_low | input | 1 | 1 for low-true PWM pulses |
| irq_en | input | 1 | Interrupt enable |
| wr_val | input | 1 | Write pulse for the value register |
| wr_data | input | CNT_W | Data for wr_val |
| flag_clr | input | 1 | Flag clear pulse |
| cap_pin | input | 1 | Asynchronous capture input |
| ch_out | output | 1 | Channel output pin |
| ch_val | output | CNT_W | Active value / captured count |
| flag | output | 1 | Channel event flag |
| irq | output | 1 | Interrupt request |

## Verification
Compare mode runs set, toggle and clear actions against a repeating 0..9 count. The toggle case shows whether a match fires once per period or more often. Capture sends rising and falling pin edges under all four edge selections. This separates a wrong synchronizer depth, which gives a wrong captured count, from a wrong edge decode, which gives a wrong flag. PWM is measured by counting high cycles over full periods for duty 0, 4 and 12 with both polarities and both alignments. A buffered write placed mid-period shows whether the active value moves early or only at the period end.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

  typedef enum logic [1:0] {
    MD_CAPT = 2'b00,
    MD_CMP  = 2'b01,
    MD_PWM  = 2'b10,
    MD_OFF  = 2'b11
  } ccp_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } ccp_act_e;

  // edge qualification: bit 0 enables rising, bit 1 enables falling
  function automatic logic edge_hit(input logic [1:0] sel,
                                    input logic rise,
                                    input logic fall);
    return (sel[0] & rise) | (sel[1] & fall);
  endfunction

  // next pin state after a compare match
  function automatic logic cmp_next(input logic [1:0] act, input logic cur);
    logic nxt;
    case (act)
      ACT_TOGGLE: nxt = ~cur;
      ACT_CLEAR:  nxt = 1'b0;
      ACT_SET:    nxt = 1'b1;
      default:    nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/ccp_sync_edge.sv
module ccp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  // STAGES synchronizer flops plus one history flop for edge detection
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[DEPTH-2:0], pin};
  end

  assign rise =  sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] &  sh[STAGES];

endmodule

// File: rtl/ccp_value_reg.sv
module ccp_value_reg
  import ccp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         wr_val,
  input  logic [W-1:0] wr_data,
  input  logic         cap_evt,
  input  logic [W-1:0] cnt,
  input  logic         reload_evt,
  output logic [W-1:0] val_q,
  output logic [W-1:0] buf_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (wr_val) buf_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else begin
      case (ccp_mode_e'(mode))
        MD_CAPT: begin
          if (cap_evt)     val_q <= cnt;
          else if (wr_val) val_q <= wr_data;
        end
        MD_PWM: begin
          if (reload_evt)  val_q <= buf_q;
        end
        default: begin
          if (wr_val)      val_q <= wr_data;
        end
      endcase
    end
  end

endmodule

// File: rtl/ccp_out_gen.sv
module ccp_out_gen
  import ccp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic [1:0]   act,
  input  logic         pol_low,
  input  logic         match_evt,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] val,
  output logic         ch_out,
  output logic         pwm_lvl
);

  // high-true PWM level: active while the count is below the value
  function automatic logic below(input logic [W-1:0] c, input logic [W-1:0] v);
    return c < v;
  endfunction

  logic pin_q;
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pin_q <= 1'b0;
    else if (mode == MD_CMP && match_evt)
      pin_q <= cmp_next(act, pin_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lvl_q <= 1'b0;
    else if (mode == MD_PWM) lvl_q <= below(cnt, val);
    else                     lvl_q <= 1'b0;
  end

  assign pwm_lvl = lvl_q;

  always_comb begin
    case (ccp_mode_e'(mode))
      MD_PWM:  ch_out = lvl_q ^ pol_low;
      MD_CMP:  ch_out = pin_q;
      default: ch_out = 1'b0;
    endcase
  end

endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
  import ccp_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_down,
  input  logic             center_mode,
  input  logic [CNT_W-1:0] mod_val,
  input  logic [1:0]       mode,
  input  logic [1:0]       edge_sel,
  input  logic [1:0]       cmp_act,
  input  logic             pol_low,
  input  logic             irq_en,
  input  logic             wr_val,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             flag_clr,
  input  logic             cap_pin,
  output logic             ch_out,
  output logic [CNT_W-1:0] ch_val,
  output logic             flag,
  output logic             irq
);

  logic             pin_rise, pin_fall;
  logic             cap_evt, match_evt, reload_evt;
  logic             at_top;
  logic [CNT_W-1:0] buf_q;
  logic             pwm_lvl;

  ccp_sync_edge #(.STAGES(SYNC_STGS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (cap_pin),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  // named internal events
  assign cap_evt    = (mode == MD_CAPT) && edge_hit(edge_sel, pin_rise, pin_fall);
  assign match_evt  = ((mode == MD_CMP) || (mode == MD_PWM)) && (cnt == ch_val);
  assign at_top     = (cnt == mod_val) && (!center_mode || !cnt_down);
  assign reload_evt = (mode == MD_PWM) && at_top;

  ccp_value_reg #(.W(CNT_W)) u_val (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .wr_val    (wr_val),
    .wr_data   (wr_data),
    .cap_evt   (cap_evt),
    .cnt       (cnt),
    .reload_evt(reload_evt),
    .val_q     (ch_val),
    .buf_q     (buf_q)
  );

  ccp_out_gen #(.W(CNT_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .act      (cmp_act),
    .pol_low  (pol_low),
    .match_evt(match_evt),
    .cnt      (cnt),
    .val      (ch_val),
    .ch_out   (ch_out),
    .pwm_lvl  (pwm_lvl)
  );

  // event flag: a new event takes priority over a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     flag <= 1'b0;
    else if (cap_evt || match_evt)  flag <= 1'b1;
    else if (flag_clr)              flag <= 1'b0;
  end

  assign irq = flag & irq_en;

endmodule

// File: rtl/ccp_channel_chk.sv
module ccp_channel_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode,
  input logic [1:0]   cmp_act,
  input logic         wr_val,
  input logic         flag_clr,
  input logic [W-1:0] cnt,
  input logic [W-1:0] mod_val,
  input logic         cap_evt,
  input logic         match_evt,
  input logic         reload_evt,
  input logic         flag,
  input logic [W-1:0] ch_val,
  input logic [W-1:0] buf_q,
  input logic         pwm_lvl,
  input logic         ch_out
);

  p_cap_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> ch_val == $past(cnt));

  p_cmp_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && mode == 2'b01 && cmp_act == 2'b11) |=> (ch_out || mode != 2'b01));

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt || match_evt) |=> flag);

  p_flag_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !cap_evt && !match_evt) |=> !flag);

  p_buf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !reload_evt) |=> $stable(ch_val));

  p_buf_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> ch_val == $past(buf_q));

  p_zero_duty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && ch_val == '0) |=> !pwm_lvl);

  p_full_duty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && ch_val > mod_val && cnt <= mod_val) |=> pwm_lvl);

  p_off_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && !wr_val) |=> $stable(ch_val));

endmodule

bind ccp_channel ccp_channel_chk #(.W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .cmp_act   (cmp_act),
  .wr_val    (wr_val),
  .flag_clr  (flag_clr),
  .cnt       (cnt),
  .mod_val   (mod_val),
  .cap_evt   (cap_evt),
  .match_evt (match_evt),
  .reload_evt(reload_evt),
  .flag      (flag),
  .ch_val    (ch_val),
  .buf_q     (buf_q),
  .pwm_lvl   (pwm_lvl),
  .ch_out    (ch_out)
);

// File: tb/sim_ccp_channel.sv
module sim_ccp_channel;
  localparam int CLK_P = 10;
  localparam int W     = 16;
  localparam int MODV  = 9;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cnt = '0;
  logic         cnt_down = 1'b0;
  logic         center_mode = 1'b0;
  logic [W-1:0] mod_val = W'(MODV);
  logic [1:0]   mode = 2'b11;
  logic [1:0]   edge_sel = 2'b00;
  logic [1:0]   cmp_act = 2'b00;
  logic         pol_low = 1'b0;
  logic         irq_en = 1'b0;
  logic         wr_val = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         flag_clr = 1'b0;
  logic         cap_pin = 1'b0;
  logic         ch_out, flag, irq;
  logic [W-1:0] ch_val;

  int    total = 0;
  int    bad = 0;
  int    hi_cnt = 0;
  string cur_req = "R1";

  // reference model state
  logic [W-1:0] m_val = '0;
  logic [W-1:0] m_buf = '0;
  logic         m_pin = 1'b0;
  logic         m_lvl = 1'b0;
  logic         m_flag = 1'b0;
  logic         pin_hist[$] = '{1'b0, 1'b0, 1'b0};

  ccp_channel #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_down(cnt_down),
    .center_mode(center_mode), .mod_val(mod_val), .mode(mode),
    .edge_sel(edge_sel), .cmp_act(cmp_act), .pol_low(pol_low),
    .irq_en(irq_en), .wr_val(wr_val), .wr_data(wr_data),
    .flag_clr(flag_clr), .cap_pin(cap_pin), .ch_out(ch_out),
    .ch_val(ch_val), .flag(flag), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every clock and compared a little later
  always @(posedge clk) begin : b_model
    logic r, f, cap, match, reload, exp_out;
    if (!rst_n) begin
      m_val = '0; m_buf = '0; m_pin = 1'b0; m_lvl = 1'b0; m_flag = 1'b0;
      pin_hist = '{1'b0, 1'b0, 1'b0};
    end else begin
      // pin_hist[k] holds the pin seen k+1 clocks ago
      r = pin_hist[1] && !pin_hist[2];
      f = !pin_hist[1] && pin_hist[2];
      cap    = (mode == 2'b00) && ((edge_sel[0] && r) || (edge_sel[1] && f));
      match  = (mode == 2'b01 || mode == 2'b10) && (int'(cnt) == int'(m_val));
      reload = (mode == 2'b10) && (int'(cnt) == MODV) && (!center_mode || !cnt_down);
      if (mode == 2'b01 && match) begin
        if (cmp_act == 2'b01)      m_pin = !m_pin;
        else if (cmp_act == 2'b10) m_pin = 1'b0;
        else if (cmp_act == 2'b11) m_pin = 1'b1;
      end
      m_lvl = (mode == 2'b10) ? (int'(cnt) < int'(m_val)) : 1'b0;
      if (cap)                      m_val = cnt;
      else if (mode == 2'b10)       begin if (reload) m_val = m_buf; end
      else if (wr_val)              m_val = wr_data;
      if (wr_val) m_buf = wr_data;
      if (cap || match)  m_flag = 1'b1;
      else if (flag_clr) m_flag = 1'b0;
      pin_hist.push_front(cap_pin);
      void'(pin_hist.pop_back());
    end
    #3;
    exp_out = (mode == 2'b10) ? (m_lvl ^ pol_low) : (mode == 2'b01) ? m_pin : 1'b0;
    chk(cur_req, "ch_out", W'(ch_out), W'(exp_out));
    chk(cur_req, "ch_val", ch_val, m_val);
    chk("R5", "flag", W'(flag), W'(m_flag));
    chk("R5", "irq", W'(irq), W'(m_flag && irq_en));
  end

  // one cycle: sample output, drop pulses, advance the counter
  task automatic step();
    @(negedge clk);
    hi_cnt += int'(ch_out);
    wr_val = 1'b0;
    flag_clr = 1'b0;
    if (!center_mode) begin
      cnt_down = 1'b0;
      cnt = (int'(cnt) == MODV) ? '0 : cnt + 1'b1;
    end else if (!cnt_down) begin
      if (int'(cnt) == MODV) begin cnt_down = 1'b1; cnt = cnt - 1'b1; end
      else cnt = cnt + 1'b1;
    end else begin
      if (cnt == '0) begin cnt_down = 1'b0; cnt = 1; end
      else cnt = cnt - 1'b1;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic write_v(input int v);
    step();
    wr_val = 1'b1;
    wr_data = W'(v);
  endtask

  task automatic clear_flag();
    step();
    flag_clr = 1'b1;
    step();
  endtask

  task automatic wait_cnt(input int v);
    for (int i = 0; i < 40; i++) begin
      if (int'(cnt) == v) break;
      step();
    end
  endtask

  initial begin : b_stim
    logic [W-1:0] v0;
    logic prev;
    int c_at;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "ch_out in reset", W'(ch_out), '0);
    chk("R1", "flag in reset", W'(flag), '0);
    chk("R1", "ch_val in reset", ch_val, '0);
    rst_n = 1'b1;
    step();
    chk("R1", "irq after reset", W'(irq), '0);

    // R4: compare set / toggle / clear
    cur_req = "R4";
    mode = 2'b01; cmp_act = 2'b11;
    write_v(5);
    run(12);
    chk("R4", "set on match", W'(ch_out), 1);
    chk("R5", "flag after match", W'(flag), 1);
    irq_en = 1'b1;
    #1 chk("R5", "irq follows enable", W'(irq), 1);
    wait_cnt(7);
    flag_clr = 1'b1;
    step();
    chk("R5", "flag cleared", W'(flag), 0);
    cmp_act = 2'b01;
    prev = ch_out;
    run(10);
    chk("R4", "one toggle per period", W'(ch_out), W'(!prev));
    cmp_act = 2'b10;
    run(10);
    chk("R4", "clear on match", W'(ch_out), 0);

    // R2 / R3: capture
    cur_req = "R2";
    mode = 2'b00; edge_sel = 2'b01;
    clear_flag();
    step();
    cap_pin = 1'b1;
    c_at = int'(cnt);
    run(3);
    chk("R2", "rise captured", W'(flag), 1);
    chk("R2", "captured count", ch_val, W'((c_at + 2) % (MODV + 1)));
    cur_req = "R3";
    clear_flag();
    cap_pin = 1'b0;
    run(5);
    chk("R3", "fall ignored when rise selected", W'(flag), 0);
    edge_sel = 2'b10;
    cap_pin = 1'b1;
    run(5);
    chk("R3", "rise ignored when fall selected", W'(flag), 0);
    cap_pin = 1'b0;
    run(5);
    chk("R3", "fall captured", W'(flag), 1);
    edge_sel = 2'b11;
    clear_flag();
    cap_pin = 1'b1;
    run(5);
    chk("R3", "either edge rise", W'(flag), 1);
    clear_flag();
    cap_pin = 1'b0;
    run(5);
    chk("R3", "either edge fall", W'(flag), 1);
    edge_sel = 2'b00;
    clear_flag();
    v0 = ch_val;
    cap_pin = 1'b1; run(4); cap_pin = 1'b0; run(4);
    chk("R3", "no edge selected flag", W'(flag), 0);
    chk("R3", "no edge selected value", ch_val, v0);
    cur_req = "R6";
    write_v(33);
    step();
    chk("R6", "direct write in capture", ch_val, 33);

    // R6 / R7: edge-aligned PWM with buffered duty
    cur_req = "R7";
    mode = 2'b10; pol_low = 1'b0; center_mode = 1'b0;
    wait_cnt(2);
    v0 = ch_val;
    wr_val = 1'b1; wr_data = 4;
    step();
    chk("R6", "buffered write not active", ch_val, v0);
    wait_cnt(0);
    chk("R6", "duty loaded at period end", ch_val, 4);
    run(10);
    hi_cnt = 0; run(10);
    chk("R7", "duty 4 of 10", W'(hi_cnt), 4);
    write_v(0); run(20);
    hi_cnt = 0; run(10);
    chk("R7", "zero duty", W'(hi_cnt), 0);
    write_v(12); run(20);
    hi_cnt = 0; run(10);
    chk("R7", "full duty", W'(hi_cnt), 10);
    cur_req = "R9";
    write_v(4); run(20);
    pol_low = 1'b1;
    #1 chk("R9", "immediate inversion", W'(ch_out), W'(!(int'(cnt) < 4) ? 1'b1 : ch_out));
    hi_cnt = 0; run(10);
    chk("R9", "low-true duty", W'(hi_cnt), 6);

    // R8: center-aligned PWM, period 18
    cur_req = "R8";
    pol_low = 1'b0; center_mode = 1'b1;
    run(40);
    hi_cnt = 0; run(18);
    chk("R8", "centered duty", W'(hi_cnt), 7);

    // R10: channel off
    cur_req = "R10";
    mode = 2'b11; center_mode = 1'b0; cnt_down = 1'b0;
    clear_flag();
    v0 = ch_val;
    cap_pin = 1'b1; run(12); cap_pin = 1'b0; run(12);
    chk("R10", "no flag when off", W'(flag), 0);
    chk("R10", "output low when off", W'(ch_out), 0);
    chk("R10", "value held when off", ch_val, v0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : b_watchdog
    #(CLK_P * 50000);
    total++;
    bad++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule